// File: doc/BRIEF.md
# Tagged-Register Decode and Execute Unit

This unit sits at the front of a small core whose registers each carry a 3-bit type tag next to a 16-bit value. Each cycle it takes one 16-bit instruction word with its program counter, splits the word into its fields, reads the tagged operands and, for every register-only operation, checks the operand tags and computes a tagged result that is written back on the next rising clock edge. It also settles the next program counter for the zero-test branch and the relative jump.

Operations that need memory, the call stack or the effect machinery are not executed. For these the unit raises a request flag and presents the decoded fields and both operand registers, so that a later stage can carry them out. That stage hands its tagged result back through a completion write port. A tag violation raises a trap, names the opcode and suppresses the write. A separate read port lets the next stage see any register combinationally.

Top module: `tagcore_exec`

## Requirements
- R1: A synchronous active-high reset sets all eight registers to tag 0 (integer) and value 0x0000.
- R2: The opcode is instr[15:11]. Opcode 0x00 writes tag 0 and the sign-extended instr[7:0] into the register that instr[10:8] selects.
- R3: Opcode 0x01 replaces the high byte of register instr[10:8] with instr[7:0]. Its low byte and its tag are kept.
- R4: Opcodes 0x02 add, 0x03 subtract, 0x14 and, 0x15 or and 0x16 xor work on registers instr[7:5] and instr[4:2]. When both carry tag 0 they write the 16-bit wrapped result with tag 0 into register instr[10:8].
- R5: Opcodes 0x17 (left shift) and 0x18 (logical right shift) shift register instr[7:5] by the low four bits of register instr[4:2]. Both operands must carry tag 0, and the result has tag 0.
- R6: Opcode 0x09 copies tag and value of register instr[7:5] into register instr[10:8].
- R7: Opcodes 0x19 (add) and 0x1A (subtract) need tag 1 (pointer) on register instr[7:5]. They apply the unsigned immediate instr[4:1] and write the wrapped result with tag 1.
- R8: When a required tag is missing, trap is high, trap_opcode holds the opcode and no register changes. With no trap, trap_opcode is 0.
- R9: Opcode 0x04 is taken when the value of register instr[10:8] is zero, whatever its tag. When taken, next_pc = pc + sign-extended instr[7:0].
- R10: Opcode 0x05 is always taken with next_pc = pc + sign-extended instr[10:0]. Any instruction that is not taken gives next_pc = pc + 1.
- R11: Opcodes 0x06-0x08, 0x0A-0x13 and 0x1B-0x1F raise ext_req and never trap or write. With them the unit presents the opcode, instr[10:8], instr[7:5], instr[10:0], instr[10:7], instr[6:3] and the tags and values of registers instr[10:8] and instr[7:5]. All ext_* outputs are zero while ext_req is low.
- R12: While instr_valid is low, trap, ext_req and branch_taken are low and the instruction writes nothing.
- R13: cpl_we writes cpl_tag and cpl_val into register cpl_sel on the clock edge. If the decoded instruction writes in the same cycle, the instruction's result wins and the completion write is dropped.
- R14: rd_tag and rd_val show the present contents of register rd_sel without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 16 | Instruction word |
| pc | input | 16 | Address of the instruction |
| cpl_we | input | 1 | Completion write enable |
| cpl_sel | input | 3 | Completion destination register |
| cpl_tag | input | 3 | Completion tag |
| cpl_val | input | 16 | Completion value |
| rd_sel | input | 3 | Read port register select |
| rd_tag | output | 3 | Read port tag |
| rd_val | output | 16 | Read port value |
| trap | output | 1 | Tag violation |
| trap_opcode | output | 5 | Opcode that trapped, else 0 |
| branch_taken | output | 1 | Control transfer taken |
| next_pc | output | 16 | Address of the next instruction |
| ext_req | output | 1 | Instruction left to a later stage |
| ext_opcode | output | 5 | Opcode of that instruction |
| ext_ra | output | 3 | Field instr[10:8] |
| ext_rb | output | 3 | Field instr[7:5] |
| ext_imm11 | output | 11 | Field instr[10:0] |
| ext_family | output | 4 | Field instr[10:7] |
| ext_effop | output | 4 | Field instr[6:3] |
| ext_a_tag | output | 3 | Tag of register ext_ra |
| ext_a_val | output | 16 | Value of register ext_ra |
| ext_b_tag | output | 3 | Tag of register ext_rb |
| ext_b_val | output | 16 | Value of register ext_rb |

## Verification
The assertions check on every cycle the invariants that tie outputs to state. Trap, request and write never occur together. Integer operations always write tag 0, pointer adjustments always write tag 1, and a logical right shift never grows the value. A taken zero-branch always sees a zero operand. A register changes only when a write is enabled, and nothing happens while no instruction is valid. Only the bench's scenarios can show exact results. These include sign extension of the immediates, shift counts of 16 and above, pointer wrap, the kept low byte and tag of the high-byte load, and a trap that leaves the register file untouched. They also include the branch targets and the outcome when a completion write collides with an instruction write.

// File: rtl/tagcore_pkg.sv
package tagcore_pkg;

    localparam int DATA_W  = 16;
    localparam int TAG_W   = 3;
    localparam int NREG    = 8;
    localparam int RIDX_W  = $clog2(NREG);
    localparam int OPC_W   = 5;
    localparam int IMM8_W  = 8;
    localparam int IMM11_W = 11;
    localparam int IMM4_W  = 4;
    localparam int FAM_W   = 4;

    typedef enum logic [TAG_W-1:0] {
        TAG_INT  = 3'd0,
        TAG_PTR  = 3'd1,
        TAG_CONT = 3'd2,
        TAG_CLOS = 3'd3,
        TAG_UNIT = 3'd4,
        TAG_BOOL = 3'd5,
        TAG_RSV6 = 3'd6,
        TAG_RSV7 = 3'd7
    } tag_e;

    typedef enum logic [OPC_W-1:0] {
        OP_LDI     = 5'h00,
        OP_LDHI    = 5'h01,
        OP_ADD     = 5'h02,
        OP_SUB     = 5'h03,
        OP_BRZ     = 5'h04,
        OP_JREL    = 5'h05,
        OP_MLOAD   = 5'h06,
        OP_MSTORE  = 5'h07,
        OP_HALLOC  = 5'h08,
        OP_MOVE    = 5'h09,
        OP_CALL    = 5'h0A,
        OP_RETURN  = 5'h0B,
        OP_DISPAT  = 5'h0C,
        OP_HINST   = 5'h0D,
        OP_HREM    = 5'h0E,
        OP_RAISE   = 5'h0F,
        OP_RESUME  = 5'h10,
        OP_SETVAR  = 5'h11,
        OP_RETAG   = 5'h12,
        OP_IDLE    = 5'h13,
        OP_AND     = 5'h14,
        OP_OR      = 5'h15,
        OP_XOR     = 5'h16,
        OP_SHL     = 5'h17,
        OP_SHR     = 5'h18,
        OP_PINC    = 5'h19,
        OP_PDEC    = 5'h1A,
        OP_FLOAD   = 5'h1B,
        OP_FSTORE  = 5'h1C,
        OP_FALLOC  = 5'h1D,
        OP_SPADJ   = 5'h1E,
        OP_TAILJ   = 5'h1F
    } opc_e;

    typedef enum logic [2:0] {
        CL_LOADIMM,
        CL_LOADHI,
        CL_INT2,
        CL_MOVE,
        CL_PTRADJ,
        CL_BRZ,
        CL_JUMP,
        CL_EXT
    } cls_e;

    typedef struct packed {
        tag_e              tag;
        logic [DATA_W-1:0] val;
    } tword_t;

    typedef struct packed {
        opc_e               opc;
        cls_e               cls;
        logic [RIDX_W-1:0]  rd;
        logic [RIDX_W-1:0]  rs;
        logic [RIDX_W-1:0]  rt;
        logic [IMM4_W-1:0]  imm4;
        logic [IMM8_W-1:0]  imm8;
        logic [IMM11_W-1:0] imm11;
        logic [FAM_W-1:0]   fam;
        logic [FAM_W-1:0]   eop;
    } dec_t;

    function automatic cls_e class_of(opc_e o);
        case (o)
            OP_LDI:                                   return CL_LOADIMM;
            OP_LDHI:                                  return CL_LOADHI;
            OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR,
            OP_SHL, OP_SHR:                           return CL_INT2;
            OP_MOVE:                                  return CL_MOVE;
            OP_PINC, OP_PDEC:                         return CL_PTRADJ;
            OP_BRZ:                                   return CL_BRZ;
            OP_JREL:                                  return CL_JUMP;
            default:                                  return CL_EXT;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] sext8(logic [IMM8_W-1:0] x);
        return {{(DATA_W-IMM8_W){x[IMM8_W-1]}}, x};
    endfunction

    function automatic logic [DATA_W-1:0] sext11(logic [IMM11_W-1:0] x);
        return {{(DATA_W-IMM11_W){x[IMM11_W-1]}}, x};
    endfunction

    function automatic logic [DATA_W-1:0] int2_result(opc_e o,
                                                      logic [DATA_W-1:0] x,
                                                      logic [DATA_W-1:0] y);
        logic [3:0] sh;
        sh = y[3:0];
        case (o)
            OP_ADD:  return x + y;
            OP_SUB:  return x - y;
            OP_AND:  return x & y;
            OP_OR:   return x | y;
            OP_XOR:  return x ^ y;
            OP_SHL:  return x << sh;
            OP_SHR:  return x >> sh;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/tagcore_decode.sv
module tagcore_decode
    import tagcore_pkg::*;
(
    input  logic [DATA_W-1:0] instr,
    output dec_t              dec
);
    localparam int OPC_LSB = DATA_W - OPC_W;

    always_comb begin
        dec.opc   = opc_e'(instr[DATA_W-1:OPC_LSB]);
        dec.cls   = class_of(dec.opc);
        dec.rd    = instr[10:8];
        dec.rs    = instr[7:5];
        dec.rt    = instr[4:2];
        dec.imm4  = instr[4:1];
        dec.imm8  = instr[IMM8_W-1:0];
        dec.imm11 = instr[IMM11_W-1:0];
        dec.fam   = instr[10:7];
        dec.eop   = instr[6:3];
    end
endmodule

// File: rtl/tagcore_regfile.sv
module tagcore_regfile
    import tagcore_pkg::*;
#(
    parameter int NRD = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [RIDX_W-1:0]           waddr,
    input  tword_t                      wdata,
    input  logic [NRD-1:0][RIDX_W-1:0]  raddr,
    output tword_t [NRD-1:0]            rdata
);
    tword_t [NREG-1:0] mem;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                mem[i] <= '{tag: TAG_INT, val: '0};
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = mem[raddr[g]];
    end

    // R8
    reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(mem));

    // R13
    reg_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/tagcore_alu.sv
module tagcore_alu
    import tagcore_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  dec_t              dec,
    input  logic [DATA_W-1:0] pc,
    input  tword_t            opa,
    input  tword_t            opb,
    input  tword_t            opc,
    output logic              wb_we,
    output tword_t            wb_data,
    output logic              trap,
    output logic              ext,
    output logic              taken,
    output logic [DATA_W-1:0] npc
);
    logic [DATA_W-1:0] off;
    logic [DATA_W-1:0] imm4_ext;

    assign imm4_ext = {{(DATA_W-IMM4_W){1'b0}}, dec.imm4};

    always_comb begin
        wb_we   = 1'b0;
        wb_data = '{tag: TAG_INT, val: '0};
        trap    = 1'b0;
        ext     = 1'b0;
        taken   = 1'b0;
        if (valid) begin
            unique case (dec.cls)
                CL_LOADIMM: begin
                    wb_we   = 1'b1;
                    wb_data = '{tag: TAG_INT, val: sext8(dec.imm8)};
                end
                CL_LOADHI: begin
                    wb_we   = 1'b1;
                    wb_data = '{tag: opa.tag, val: {dec.imm8, opa.val[IMM8_W-1:0]}};
                end
                CL_INT2: begin
                    if (opb.tag != TAG_INT || opc.tag != TAG_INT) begin
                        trap = 1'b1;
                    end else begin
                        wb_we   = 1'b1;
                        wb_data = '{tag: TAG_INT, val: int2_result(dec.opc, opb.val, opc.val)};
                    end
                end
                CL_MOVE: begin
                    wb_we   = 1'b1;
                    wb_data = opb;
                end
                CL_PTRADJ: begin
                    if (opb.tag != TAG_PTR) begin
                        trap = 1'b1;
                    end else begin
                        wb_we   = 1'b1;
                        wb_data.tag = TAG_PTR;
                        wb_data.val = (dec.opc == OP_PINC) ? opb.val + imm4_ext
                                                           : opb.val - imm4_ext;
                    end
                end
                CL_BRZ:  taken = (opa.val == '0);
                CL_JUMP: taken = 1'b1;
                CL_EXT:  ext = 1'b1;
                default: ext = 1'b0;
            endcase
        end
    end

    assign off = (dec.cls == CL_BRZ) ? sext8(dec.imm8) : sext11(dec.imm11);
    assign npc = taken ? pc + off : pc + 1'b1;

    // R8
    trap_ext_we_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({trap, ext, wb_we}));

    // R4
    int_result_tag_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_we && dec.cls == CL_INT2) |-> (wb_data.tag == TAG_INT));

    // R7
    ptr_result_tag_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_we && dec.cls == CL_PTRADJ) |-> (wb_data.tag == TAG_PTR));

    // R5
    shr_no_growth_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_we && dec.opc == OP_SHR) |-> (wb_data.val <= opb.val));

    // R9
    brz_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (taken && dec.cls == CL_BRZ) |-> (opa.val == '0));

    // R10
    jump_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && dec.cls == CL_JUMP) |-> (taken && npc != pc + 1'b1 || off == 16'd1));
endmodule

// File: rtl/tagcore_exec.sv
module tagcore_exec
    import tagcore_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         instr_valid,
    input  logic [15:0]  instr,
    input  logic [15:0]  pc,
    input  logic         cpl_we,
    input  logic [2:0]   cpl_sel,
    input  logic [2:0]   cpl_tag,
    input  logic [15:0]  cpl_val,
    input  logic [2:0]   rd_sel,
    output logic [2:0]   rd_tag,
    output logic [15:0]  rd_val,
    output logic         trap,
    output logic [4:0]   trap_opcode,
    output logic         branch_taken,
    output logic [15:0]  next_pc,
    output logic         ext_req,
    output logic [4:0]   ext_opcode,
    output logic [2:0]   ext_ra,
    output logic [2:0]   ext_rb,
    output logic [10:0]  ext_imm11,
    output logic [3:0]   ext_family,
    output logic [3:0]   ext_effop,
    output logic [2:0]   ext_a_tag,
    output logic [15:0]  ext_a_val,
    output logic [2:0]   ext_b_tag,
    output logic [15:0]  ext_b_val
);
    localparam int NRD    = 4;
    localparam int RP_A   = 0;
    localparam int RP_B   = 1;
    localparam int RP_C   = 2;
    localparam int RP_DBG = 3;

    dec_t                       dec;
    logic [NRD-1:0][RIDX_W-1:0] raddr;
    tword_t [NRD-1:0]           rdata;
    logic                       alu_we;
    tword_t                     alu_data;
    logic                       alu_trap;
    logic                       alu_ext;
    logic                       rf_we;
    logic [RIDX_W-1:0]          rf_waddr;
    tword_t                     rf_wdata;

    tagcore_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    always_comb begin
        raddr[RP_A]   = dec.rd;
        raddr[RP_B]   = dec.rs;
        raddr[RP_C]   = dec.rt;
        raddr[RP_DBG] = rd_sel;
    end

    tagcore_regfile #(.NRD(NRD)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .raddr (raddr),
        .rdata (rdata)
    );

    tagcore_alu u_alu (
        .clk     (clk),
        .rst     (rst),
        .valid   (instr_valid),
        .dec     (dec),
        .pc      (pc),
        .opa     (rdata[RP_A]),
        .opb     (rdata[RP_B]),
        .opc     (rdata[RP_C]),
        .wb_we   (alu_we),
        .wb_data (alu_data),
        .trap    (alu_trap),
        .ext     (alu_ext),
        .taken   (branch_taken),
        .npc     (next_pc)
    );

    // instruction result has priority over the completion port
    always_comb begin
        if (alu_we) begin
            rf_we    = 1'b1;
            rf_waddr = dec.rd;
            rf_wdata = alu_data;
        end else begin
            rf_we    = cpl_we;
            rf_waddr = cpl_sel;
            rf_wdata = '{tag: tag_e'(cpl_tag), val: cpl_val};
        end
    end

    assign rd_tag      = rdata[RP_DBG].tag;
    assign rd_val      = rdata[RP_DBG].val;
    assign trap        = alu_trap;
    assign trap_opcode = alu_trap ? dec.opc : '0;
    assign ext_req     = alu_ext;

    always_comb begin
        ext_opcode = '0;
        ext_ra     = '0;
        ext_rb     = '0;
        ext_imm11  = '0;
        ext_family = '0;
        ext_effop  = '0;
        ext_a_tag  = '0;
        ext_a_val  = '0;
        ext_b_tag  = '0;
        ext_b_val  = '0;
        if (alu_ext) begin
            ext_opcode = dec.opc;
            ext_ra     = dec.rd;
            ext_rb     = dec.rs;
            ext_imm11  = dec.imm11;
            ext_family = dec.fam;
            ext_effop  = dec.eop;
            ext_a_tag  = rdata[RP_A].tag;
            ext_a_val  = rdata[RP_A].val;
            ext_b_tag  = rdata[RP_B].tag;
            ext_b_val  = rdata[RP_B].val;
        end
    end

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |-> (!trap && !ext_req && !branch_taken && !alu_we));

    // R11
    ext_no_trap_chk: assert property (@(posedge clk) disable iff (rst)
        ext_req |-> (!trap && trap_opcode == '0));
endmodule

// File: tb/tagcore_exec_tb_top.sv
`timescale 1ns/10ps
module tagcore_exec_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] pc = '0;
    logic        cpl_we = 1'b0;
    logic [2:0]  cpl_sel = '0;
    logic [2:0]  cpl_tag = '0;
    logic [15:0] cpl_val = '0;
    logic [2:0]  rd_sel = '0;
    logic [2:0]  rd_tag;
    logic [15:0] rd_val;
    logic        trap;
    logic [4:0]  trap_opcode;
    logic        branch_taken;
    logic [15:0] next_pc;
    logic        ext_req;
    logic [4:0]  ext_opcode;
    logic [2:0]  ext_ra, ext_rb;
    logic [10:0] ext_imm11;
    logic [3:0]  ext_family, ext_effop;
    logic [2:0]  ext_a_tag, ext_b_tag;
    logic [15:0] ext_a_val, ext_b_val;

    always #2 clk = ~clk;

    tagcore_exec dut_i (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr(instr), .pc(pc),
        .cpl_we(cpl_we), .cpl_sel(cpl_sel), .cpl_tag(cpl_tag), .cpl_val(cpl_val),
        .rd_sel(rd_sel), .rd_tag(rd_tag), .rd_val(rd_val),
        .trap(trap), .trap_opcode(trap_opcode), .branch_taken(branch_taken),
        .next_pc(next_pc), .ext_req(ext_req), .ext_opcode(ext_opcode),
        .ext_ra(ext_ra), .ext_rb(ext_rb), .ext_imm11(ext_imm11),
        .ext_family(ext_family), .ext_effop(ext_effop),
        .ext_a_tag(ext_a_tag), .ext_a_val(ext_a_val),
        .ext_b_tag(ext_b_tag), .ext_b_val(ext_b_val)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [2:0]  m_tag [8];
    logic [15:0] m_val [8];

    logic        e_we, e_trap, e_ext, e_taken;
    logic [2:0]  e_tag;
    logic [15:0] e_val, e_npc;

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // expected behaviour, from the requirements
    task automatic calc(input logic iv, input logic [15:0] ins, input logic [15:0] pcv);
        logic [4:0]  op;
        logic [2:0]  d, s, t;
        op = ins[15:11]; d = ins[10:8]; s = ins[7:5]; t = ins[4:2];
        e_we = 0; e_trap = 0; e_ext = 0; e_taken = 0; e_npc = pcv + 16'd1;
        e_tag = 0; e_val = 0;
        if (iv) begin
            case (op)
                5'h00: begin e_we = 1; e_val = {{8{ins[7]}}, ins[7:0]}; end
                5'h01: begin e_we = 1; e_tag = m_tag[d]; e_val = {ins[7:0], m_val[d][7:0]}; end
                5'h02, 5'h03, 5'h14, 5'h15, 5'h16, 5'h17, 5'h18: begin
                    if (m_tag[s] != 0 || m_tag[t] != 0) e_trap = 1;
                    else begin
                        e_we = 1;
                        case (op)
                            5'h02: e_val = m_val[s] + m_val[t];
                            5'h03: e_val = m_val[s] - m_val[t];
                            5'h14: e_val = m_val[s] & m_val[t];
                            5'h15: e_val = m_val[s] | m_val[t];
                            5'h16: e_val = m_val[s] ^ m_val[t];
                            5'h17: e_val = m_val[s] << m_val[t][3:0];
                            default: e_val = m_val[s] >> m_val[t][3:0];
                        endcase
                    end
                end
                5'h04: if (m_val[d] == 0) begin
                    e_taken = 1; e_npc = pcv + {{8{ins[7]}}, ins[7:0]};
                end
                5'h05: begin e_taken = 1; e_npc = pcv + {{5{ins[10]}}, ins[10:0]}; end
                5'h09: begin e_we = 1; e_tag = m_tag[s]; e_val = m_val[s]; end
                5'h19, 5'h1A: begin
                    if (m_tag[s] != 1) e_trap = 1;
                    else begin
                        e_we = 1; e_tag = 1;
                        e_val = (op == 5'h19) ? m_val[s] + {12'd0, ins[4:1]}
                                              : m_val[s] - {12'd0, ins[4:1]};
                    end
                end
                default: e_ext = 1;
            endcase
        end
    endtask

    task automatic check_regs(input string rq);
        for (int i = 0; i < 8; i++) begin
            rd_sel = 3'(i);
            #0.1;
            chk(rq, $sformatf("reg%0d tag", i), {29'd0, rd_tag}, {29'd0, m_tag[i]});
            chk(rq, $sformatf("reg%0d val", i), {16'd0, rd_val}, {16'd0, m_val[i]});
        end
    endtask

    task automatic step(input string rq, input logic iv, input logic [15:0] ins,
                        input logic [15:0] pcv, input logic cwe, input logic [2:0] csel,
                        input logic [2:0] ctag, input logic [15:0] cval);
        logic [2:0] d;
        d = ins[10:8];
        @(negedge clk);
        instr_valid = iv; instr = ins; pc = pcv;
        cpl_we = cwe; cpl_sel = csel; cpl_tag = ctag; cpl_val = cval;
        #0.5;
        calc(iv, ins, pcv);
        chk(rq, "trap", {31'd0, trap}, {31'd0, e_trap});
        chk(rq, "trap_opcode", {27'd0, trap_opcode}, e_trap ? {27'd0, ins[15:11]} : 32'd0);
        chk(rq, "ext_req", {31'd0, ext_req}, {31'd0, e_ext});
        chk(rq, "branch_taken", {31'd0, branch_taken}, {31'd0, e_taken});
        chk(rq, "next_pc", {16'd0, next_pc}, {16'd0, e_npc});
        if (e_ext) begin
            chk("R11", "ext fields", {ext_opcode, ext_ra, ext_rb, ext_imm11, 10'd0},
                {ins[15:11], ins[10:8], ins[7:5], ins[10:0], 10'd0});
            chk("R11", "ext fam/op", {24'd0, ext_family, ext_effop}, {24'd0, ins[10:7], ins[6:3]});
            chk("R11", "ext a", {ext_a_tag, 13'd0, ext_a_val}, {m_tag[d], 13'd0, m_val[d]});
            chk("R11", "ext b", {ext_b_tag, 13'd0, ext_b_val},
                {m_tag[ins[7:5]], 13'd0, m_val[ins[7:5]]});
        end else begin
            chk("R11", "ext idle", {27'd0, ext_opcode}, 32'd0);
        end
        @(posedge clk);
        #0.5;
        if (e_we) begin
            m_tag[d] = e_tag; m_val[d] = e_val;
        end else if (cwe) begin
            m_tag[csel] = ctag; m_val[csel] = cval;
        end
        instr_valid = 0; cpl_we = 0;
        check_regs(rq);
    endtask

    function automatic logic [15:0] mk_r3(input logic [4:0] op, input logic [2:0] d,
                                           input logic [2:0] s, input logic [2:0] t);
        return {op, d, s, t, 2'b00};
    endfunction

    initial begin
        for (int i = 0; i < 8; i++) begin m_tag[i] = 0; m_val[i] = 0; end
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #0.5 rst = 0;
        // R1 reset state
        check_regs("R1");
        // R12 idle with nothing valid
        step("R12", 0, 16'h1234, 16'h0100, 0, 0, 0, 0);
        // R2 sign extension of negative immediate
        step("R2", 1, {5'h00, 3'd2, 8'h80}, 16'h0010, 0, 0, 0, 0);
        // R13 completion loads a pointer into r3
        step("R13", 0, 16'h0, 16'h0, 1, 3'd3, 3'd1, 16'h0005);
        // R3 high byte load keeps pointer tag and low byte
        step("R3", 1, {5'h01, 3'd3, 8'hA7}, 16'h0020, 0, 0, 0, 0);
        // R7 pointer decrement wraps below zero
        step("R13", 0, 16'h0, 16'h0, 1, 3'd4, 3'd1, 16'h0000);
        step("R7", 1, {5'h1A, 3'd5, 3'd4, 4'hF, 1'b0}, 16'h0030, 0, 0, 0, 0);
        step("R7", 1, {5'h19, 3'd6, 3'd3, 4'h9, 1'b1}, 16'h0031, 0, 0, 0, 0);
        // R8 pointer op on integer traps and writes nothing
        step("R8", 1, {5'h19, 3'd1, 3'd2, 4'h3, 1'b0}, 16'h0040, 0, 0, 0, 0);
        // R8 add with a pointer operand traps
        step("R8", 1, mk_r3(5'h02, 3'd0, 3'd2, 3'd3), 16'h0041, 0, 0, 0, 0);
        // R5 shift count 17 masks to 1; logical right shift of 0x8000
        step("R13", 0, 16'h0, 16'h0, 1, 3'd7, 3'd0, 16'h0011);
        step("R13", 0, 16'h0, 16'h0, 1, 3'd1, 3'd0, 16'h8000);
        step("R5", 1, mk_r3(5'h17, 3'd0, 3'd1, 3'd7), 16'h0050, 0, 0, 0, 0);
        step("R13", 0, 16'h0, 16'h0, 1, 3'd7, 3'd0, 16'h000F);
        step("R5", 1, mk_r3(5'h18, 3'd0, 3'd1, 3'd7), 16'h0051, 0, 0, 0, 0);
        // R6 move copies a pointer tag
        step("R6", 1, mk_r3(5'h09, 3'd2, 3'd6, 3'd0), 16'h0060, 0, 0, 0, 0);
        // R9 branch on zero, backwards, tag ignored
        step("R13", 0, 16'h0, 16'h0, 1, 3'd4, 3'd5, 16'h0000);
        step("R9", 1, {5'h04, 3'd4, 8'hF0}, 16'h0070, 0, 0, 0, 0);
        step("R9", 1, {5'h04, 3'd1, 8'h10}, 16'h0071, 0, 0, 0, 0);
        // R10 jump backwards
        step("R10", 1, {5'h05, 11'h400}, 16'h0100, 0, 0, 0, 0);
        // R11 effect-form opcode presents fields
        step("R11", 1, {5'h0F, 4'hA, 4'h5, 3'd6}, 16'h0110, 0, 0, 0, 0);
        // R13 collision: instruction wins
        step("R13", 1, {5'h00, 3'd3, 8'h22}, 16'h0120, 1, 3'd5, 3'd2, 16'hBEEF);
        // R13 completion lands beside an external opcode
        step("R13", 1, {5'h06, 3'd1, 3'd2, 5'd3}, 16'h0121, 1, 3'd5, 3'd2, 16'hBEEF);
        // R14 read port is sampled every step; mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            int sel;
            logic [2:0] tg;
            sel = $urandom % 10;
            tg = ($urandom % 3 == 0) ? 3'd1 : 3'($urandom % 8);
            if (sel < 3)
                step("R14", 0, 16'($urandom), 16'($urandom), 1, 3'($urandom), tg, 16'($urandom));
            else if (sel == 3)
                step("R13", 1, 16'($urandom), 16'($urandom), 1, 3'($urandom), tg, 16'($urandom));
            else
                step("R4", 1, 16'($urandom), 16'($urandom), 0, 0, 0, 0);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule